// File: doc/BRIEF.md
# Counting Semaphore Cell with Error Control Register

This block is one counting-semaphore storage cell for synchronising threads, together with the shared interrupt and error control register. Requesters reach it through a single request port. Each request carries a 4-bit view code, a write flag, a requester number and write data. Every completed access returns a registered response one cycle later.

A read in the semaphore views is a P (take) operation and a write is a V (give) operation. The sync view blocks and the try view does not. In the sync view, a take on an empty count is parked: no response is sent, and the requester's bit is set in an exposed waiting mask. The next give releases every waiter. The lowest-numbered waiter is answered on a separate release channel. The others see their bit drop and must retry.

A third view reaches the control register. Its low three bits are error flags that software clears by writing ones. Bits [10:8] hold a grain field that writes can only raise. Any access with a view code the cell does not serve is rejected. A rejected access sets the bus error flag in the register and returns an error response.

Top module: `sema_cell`

## Requirements
- R1: After reset the count is 0, the waiting mask is 0, no response is pending, and the control register reads NUM_CELLS in bits [23:16], GRAIN_RST in bits [10:8] and 0 in the error bits [2:0].
- R2: A read in the sync view (code 4'h4) or the try view (code 4'h5) with a non-zero count answers on the next cycle with the count before the access, then lowers the count by one.
- R3: A read in the try view with a zero count answers 0 on the next cycle and leaves the count at 0.
- R4: A read in the sync view with a zero count sends no response and sets bit req_id_i of wait_mask_o. The mask is non-zero only while the count is 0.
- R5: A write in either semaphore view ignores its data, answers with 0, and raises the count by one, holding at 2^CNT_W-1 once that value is reached.
- R6: A write in either semaphore view that finds a non-empty waiting mask clears the mask. On the next cycle it answers the lowest-numbered waiter on the release channel with the raised count. The count then drops by one for that waiter.
- R7: A read in the control view (code 4'h6) answers with the whole control register.
- R8: A write in the control view clears each error bit in [2:0] whose data bit is 1 and leaves the others. Bit 2 is bus error, bit 1 is parity error and bit 0 is execution error.
- R9: A write in the control view ORs data bits [10:8] into the grain field. No write ever clears a grain bit.
- R10: An access with any other view code answers with bus_err_o high and read data 0. It sets control bit 2 and changes neither the count nor the waiting mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one access per cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_view_i | input | 4 | View code |
| req_id_i | input | ID_W | Requester number |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response strobe |
| bus_err_o | output | 1 | Response is a bus error |
| rsp_id_o | output | ID_W | Requester of the response |
| rsp_rdata_o | output | DATA_W | Response read data |
| rel_valid_o | output | 1 | Release answer to a parked requester |
| rel_id_o | output | ID_W | Released requester |
| rel_rdata_o | output | DATA_W | Count handed to the released requester |
| wait_mask_o | output | N_REQ | Parked requesters |

## Verification
The bench builds the cell with CNT_W=4, N_REQ=4, NUM_CELLS=3 and GRAIN_RST=2. The narrow counter brings saturation within about twenty gives, so the hold at 15 and the take that follows it are checked directly. Four requesters allow two parked waiters with a gap below them, which shows that the release picks the lowest set bit. The non-zero reset fields make the control register's grain and cell-count bits visible. They also show that clearing an error bit leaves those fields alone.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam logic [3:0] VIEW_SYNC = 4'h4;
  localparam logic [3:0] VIEW_TRY  = 4'h5;
  localparam logic [3:0] VIEW_CTRL = 4'h6;

  localparam int CTRL_W     = 32;
  localparam int ERR_BUS    = 2;
  localparam int ERR_PAR    = 1;
  localparam int ERR_EXEC   = 0;
  localparam int GRAIN_LSB  = 8;
  localparam int GRAIN_W    = 3;
  localparam int CELLS_LSB  = 16;
  localparam int CELLS_W    = 8;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_P_SYNC,
    OP_P_TRY,
    OP_V,
    OP_CTRL_RD,
    OP_CTRL_WR,
    OP_BAD
  } op_e;
endpackage

// File: rtl/sema_view_dec.sv
module sema_view_dec
  import sema_pkg::*;
(
  input  logic       req_i,
  input  logic       we_i,
  input  logic [3:0] view_i,
  output op_e        op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (req_i) begin
      unique case (view_i)
        VIEW_SYNC: op_o = we_i ? OP_V : OP_P_SYNC;
        VIEW_TRY:  op_o = we_i ? OP_V : OP_P_TRY;
        VIEW_CTRL: op_o = we_i ? OP_CTRL_WR : OP_CTRL_RD;
        default:   op_o = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/sema_count.sv
module sema_count
  import sema_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_REQ = 4,
  parameter int ID_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic [ID_W-1:0]  id_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             stall_o,
  output logic             rel_valid_o,
  output logic [ID_W-1:0]  rel_id_o,
  output logic [CNT_W-1:0] rel_data_o,
  output logic [N_REQ-1:0] wait_mask_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [N_REQ-1:0] mask_q, mask_d;
  logic             rel_fire;
  logic [ID_W-1:0]  rel_sel;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  // lowest set waiter wins the release
  always_comb begin
    rel_sel = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (mask_q[i]) rel_sel = ID_W'(i);
    end
  end

  always_comb begin
    cnt_d    = cnt_q;
    mask_d   = mask_q;
    stall_o  = 1'b0;
    rel_fire = 1'b0;
    unique case (op_i)
      OP_P_SYNC, OP_P_TRY: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (op_i == OP_P_SYNC) begin
          mask_d  = mask_q | (N_REQ'(1) << id_i);
          stall_o = 1'b1;
        end
      end
      OP_V: begin
        if (mask_q != '0) begin
          mask_d   = '0;
          rel_fire = 1'b1;
          cnt_d    = cnt_inc - 1'b1;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      mask_q      <= '0;
      rel_valid_o <= 1'b0;
      rel_id_o    <= '0;
      rel_data_o  <= '0;
    end else begin
      cnt_q       <= cnt_d;
      mask_q      <= mask_d;
      rel_valid_o <= rel_fire;
      if (rel_fire) begin
        rel_id_o   <= rel_sel;
        rel_data_o <= cnt_inc;
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign wait_mask_o = mask_q;

  AST_WAIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q != '0) |-> (cnt_q == '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_V && cnt_q == CNT_MAX && mask_q == '0) |=> (cnt_q == CNT_MAX)); // R5
  AST_P_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_P_SYNC || op_i == OP_P_TRY) && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
  AST_REL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_V && mask_q != '0) |=> (mask_q == '0 && rel_valid_o)); // R6
  AST_BAD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BAD) |=> ($stable(cnt_q) && $stable(mask_q))); // R10
endmodule

// File: rtl/sema_ctrl_reg.sv
module sema_ctrl_reg
  import sema_pkg::*;
#(
  parameter int NUM_CELLS = 1,
  parameter int GRAIN_RST = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam logic [CTRL_W-1:0] RST_VAL =
    (CTRL_W'(NUM_CELLS) << CELLS_LSB) | (CTRL_W'(GRAIN_RST) << GRAIN_LSB);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= RST_VAL;
    end else begin
      unique case (op_i)
        OP_BAD: ctrl_q[ERR_BUS] <= 1'b1;
        OP_CTRL_WR: begin
          ctrl_q[2:0] <= ctrl_q[2:0] & ~wdata_i[2:0];
          ctrl_q[GRAIN_LSB +: GRAIN_W] <=
            ctrl_q[GRAIN_LSB +: GRAIN_W] | wdata_i[GRAIN_LSB +: GRAIN_W];
        end
        default: ;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;

  AST_BUS_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BAD) |=> ctrl_q[ERR_BUS]); // R10
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CTRL_WR && wdata_i[ERR_BUS]) |=> !ctrl_q[ERR_BUS]); // R8
  AST_GRAIN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ctrl_q[GRAIN_LSB +: GRAIN_W] & $past(ctrl_q[GRAIN_LSB +: GRAIN_W]))
              == $past(ctrl_q[GRAIN_LSB +: GRAIN_W]))); // R9
endmodule

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int N_REQ     = 4,
  parameter int NUM_CELLS = 1,
  parameter int GRAIN_RST = 0,
  parameter int DATA_W    = 32,
  localparam int ID_W     = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [3:0]        req_view_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              bus_err_o,
  output logic [ID_W-1:0]   rsp_id_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rel_valid_o,
  output logic [ID_W-1:0]   rel_id_o,
  output logic [DATA_W-1:0] rel_rdata_o,
  output logic [N_REQ-1:0]  wait_mask_o
);
  op_e               op;
  logic [CNT_W-1:0]  cnt;
  logic              stall;
  logic [CNT_W-1:0]  rel_data;
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] rdata_d;

  sema_view_dec u_dec (
    .req_i  (req_i),
    .we_i   (req_we_i),
    .view_i (req_view_i),
    .op_o   (op)
  );

  sema_count #(.CNT_W(CNT_W), .N_REQ(N_REQ), .ID_W(ID_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .id_i        (req_id_i),
    .cnt_o       (cnt),
    .stall_o     (stall),
    .rel_valid_o (rel_valid_o),
    .rel_id_o    (rel_id_o),
    .rel_data_o  (rel_data),
    .wait_mask_o (wait_mask_o)
  );

  sema_ctrl_reg #(.NUM_CELLS(NUM_CELLS), .GRAIN_RST(GRAIN_RST)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .wdata_i (CTRL_W'(req_wdata_i)),
    .ctrl_o  (ctrl)
  );

  always_comb begin
    unique case (op)
      OP_P_SYNC, OP_P_TRY: rdata_d = DATA_W'(cnt);
      OP_CTRL_RD:          rdata_d = DATA_W'(ctrl);
      default:             rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      bus_err_o   <= 1'b0;
      rsp_id_o    <= '0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= (op != OP_NONE) && !stall;
      bus_err_o   <= (op == OP_BAD);
      if (op != OP_NONE) begin
        rsp_id_o    <= req_id_i;
        rsp_rdata_o <= rdata_d;
      end
    end
  end

  assign rel_rdata_o = DATA_W'(rel_data);

  AST_RSP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o); // R2
  AST_ERR_WITH_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> rsp_valid_o); // R10
  AST_PARK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !req_we_i && req_view_i == VIEW_SYNC && wait_mask_o == '0 && rsp_valid_o == rsp_valid_o
     && stall) |=> !rsp_valid_o); // R4
endmodule

// File: tb/tb_sema_cell.sv
module tb_sema_cell;
  localparam int CNT_W = 4;
  localparam int N_REQ = 4;
  localparam int DW    = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  view = '0;
  logic [1:0]  id = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid, bus_err, rel_valid;
  logic [1:0]  rsp_id, rel_id;
  logic [31:0] rsp_rdata, rel_rdata;
  logic [3:0]  wmask;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sema_cell #(.CNT_W(CNT_W), .N_REQ(N_REQ), .NUM_CELLS(3), .GRAIN_RST(2), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(we), .req_view_i(view),
    .req_id_i(id), .req_wdata_i(wdata), .rsp_valid_o(rsp_valid), .bus_err_o(bus_err),
    .rsp_id_o(rsp_id), .rsp_rdata_o(rsp_rdata), .rel_valid_o(rel_valid),
    .rel_id_o(rel_id), .rel_rdata_o(rel_rdata), .wait_mask_o(wmask)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  view;
    logic [1:0]  id;
    logic [31:0] wd;
    logic        ev;
    logic        eerr;
    logic [31:0] erd;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'h5, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,        8'd3},  // R3
    '{1'b1, 4'h4, 2'd0, 32'hBEEF, 1'b1, 1'b0, 32'h0,        8'd5},  // R5
    '{1'b1, 4'h5, 2'd1, 32'h0,    1'b1, 1'b0, 32'h0,        8'd5},  // R5
    '{1'b0, 4'h4, 2'd2, 32'h0,    1'b1, 1'b0, 32'h2,        8'd2},  // R2
    '{1'b0, 4'h5, 2'd3, 32'h0,    1'b1, 1'b0, 32'h1,        8'd2},  // R2
    '{1'b0, 4'h5, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,        8'd3},  // R3
    '{1'b0, 4'h6, 2'd0, 32'h0,    1'b1, 1'b0, 32'h00030200, 8'd7},  // R7
    '{1'b1, 4'h6, 2'd0, 32'h100,  1'b1, 1'b0, 32'h0,        8'd9},  // R9
    '{1'b0, 4'h6, 2'd0, 32'h0,    1'b1, 1'b0, 32'h00030300, 8'd9},  // R9
    '{1'b0, 4'h0, 2'd1, 32'h0,    1'b1, 1'b1, 32'h0,        8'd10}, // R10
    '{1'b0, 4'h6, 2'd0, 32'h0,    1'b1, 1'b0, 32'h00030304, 8'd10}, // R10
    '{1'b1, 4'h6, 2'd0, 32'h7,    1'b1, 1'b0, 32'h0,        8'd8},  // R8
    '{1'b0, 4'h6, 2'd0, 32'h0,    1'b1, 1'b0, 32'h00030300, 8'd8},  // R8
    '{1'b1, 4'hF, 2'd2, 32'h1,    1'b1, 1'b1, 32'h0,        8'd10}, // R10
    '{1'b0, 4'h5, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,        8'd10}  // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample the registered response one cycle later
  task automatic access(input logic w, input logic [3:0] v, input logic [1:0] i,
                        input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; view = v; id = i; wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check("R1 wait_mask", 32'(wmask), 32'h0);
    check("R1 rel_valid", 32'(rel_valid), 32'h0);

    for (int k = 0; k < NV; k++) begin
      access(TBL[k].we, TBL[k].view, TBL[k].id, TBL[k].wd);
      n_run++;
      if (rsp_valid !== TBL[k].ev || bus_err !== TBL[k].eerr ||
          rsp_rdata !== TBL[k].erd || rsp_id !== TBL[k].id) begin
        n_fail++;
        $display("FAIL R%0d row %0d: got v=%b e=%b id=%0d d=%h expected v=%b e=%b id=%0d d=%h",
                 TBL[k].rq, k, rsp_valid, bus_err, rsp_id, rsp_rdata,
                 TBL[k].ev, TBL[k].eerr, TBL[k].id, TBL[k].erd);
      end
    end

    // R5 saturation at 15
    for (int k = 0; k < 20; k++) access(1'b1, 4'h5, 2'd0, 32'hFFFF_FFFF);
    access(1'b0, 4'h5, 2'd0, 32'h0);
    check("R5 saturated count", rsp_rdata, 32'd15);
    access(1'b0, 4'h4, 2'd0, 32'h0);
    check("R2 after saturation", rsp_rdata, 32'd14);
    for (int k = 0; k < 14; k++) access(1'b0, 4'h5, 2'd0, 32'h0);
    access(1'b0, 4'h5, 2'd0, 32'h0);
    check("R3 drained", rsp_rdata, 32'd0);

    // R4 parking two waiters
    access(1'b0, 4'h4, 2'd3, 32'h0);
    check("R4 no response", 32'(rsp_valid), 32'h0);
    check("R4 mask id3", 32'(wmask), 32'h8);
    access(1'b0, 4'h4, 2'd1, 32'h0);
    check("R4 mask id1", 32'(wmask), 32'hA);

    // R6 give releases lowest waiter
    access(1'b1, 4'h4, 2'd0, 32'h55);
    check("R6 give ack", 32'(rsp_valid), 32'h1);
    check("R6 release valid", 32'(rel_valid), 32'h1);
    check("R6 release id", 32'(rel_id), 32'h1);
    check("R6 release data", rel_rdata, 32'h1);
    check("R6 mask cleared", 32'(wmask), 32'h0);
    @(negedge clk);
    check("R6 release single pulse", 32'(rel_valid), 32'h0);
    access(1'b0, 4'h5, 2'd3, 32'h0);
    check("R6 count after release", rsp_rdata, 32'h0);

    // R10 rejected access leaves mask untouched
    access(1'b0, 4'h4, 2'd2, 32'h0);
    access(1'b1, 4'h9, 2'd0, 32'h0);
    check("R10 err flag", 32'(bus_err), 32'h1);
    check("R10 mask kept", 32'(wmask), 32'h4);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 mask after reset", 32'(wmask), 32'h0);
    access(1'b0, 4'h6, 2'd0, 32'h0);
    check("R1 ctrl after reset", rsp_rdata, 32'h00030200);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule